// File: doc/BRIEF.md
# Weighted-In, Weighted-Out Adder Modulo 2^n+1

This block adds two residues modulo 2^n+1 and returns their sum modulo 2^n+1. Operands and result are plain weighted binary values of n+1 bits, legal from 0 up to 2^n. It is one channel adder of a residue number system datapath, where the 2^n+1 channel should not be slower than the 2^n and 2^n-1 channels beside it.

Inside, each nonzero operand is taken to its diminished-one code (value minus one, n bits) by a short borrow-prefix stage. The two codes are added on an n-bit parallel-prefix core whose carry-in is the inverted carry-out of the same sum, fed back around the end. The core result is brought back to weighted form by an n-bit incrementer that also sets the top bit. Zero operands and a sum that wraps to zero bypass the core through explicit flags, so the value 2^n, whose low n bits are zero, never takes the place of 0. The block is purely combinational and the width n is a parameter (n >= 2).

Top module: `wmod_adder`

## Requirements
- R1: For every pair of legal operands (0 to 2^n), `sum_o` equals (op_a + op_b) mod (2^n+1).
- R2: `sum_o` always lies in 0 to 2^n.
- R3: A zero operand is an identity: op_a = 0 gives `sum_o` = op_b, and op_b = 0 gives `sum_o` = op_a.
- R4: Two operands of 2^n (bit n set, low bits clear) give 2^n - 1.
- R5: A pair whose plain sum is exactly 2^n+1 (for example 1 and 2^n) gives 0.
- R6: A pair whose plain sum is exactly 2^n (for example 2^n and 0, or k and 2^n-k) gives 2^n, with bit n set and the low n bits clear, never 0.
- R7: The block has no clock or state; `sum_o` follows a change of the operands within the same cycle.
- R8: The diminished-one code of each operand, plus one, equals the operand's low n bits modulo 2^n, and the carry datapath is n bits wide.
- R9: Width n is a parameter; the same source gives correct sums at n = 3 and at n = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N+1 | First weighted residue, 0 to 2^N |
| op_b | input | N+1 | Second weighted residue, 0 to 2^N |
| sum_o | output | N+1 | Weighted residue of (op_a + op_b) mod (2^N+1) |

## Verification
The inverted end-around carry and the zero-sum override are both active in one evaluation whenever the plain sum is exactly 2^n+1: the core then wraps to an all-zero code and the override must turn the result into 0 rather than 1. Complementary pairs (k, 2^n+1-k) are driven on purpose, including 1 with 2^n, and the result is compared against 0 by a bench function that uses ordinary integer remainder. The neighbouring case, pairs summing to exactly 2^n where the incrementer must carry into bit n, is driven beside it so a confusion between 2^n and 0 shows up on the same inputs.

// File: rtl/wmod_pkg.sv
package wmod_pkg;

  // Output path chosen by the flag logic
  typedef enum logic [1:0] {
    PATH_ZERO = 2'd0,
    PATH_A    = 2'd1,
    PATH_B    = 2'd2,
    PATH_CORE = 2'd3
  } wmod_path_e;

  // Prefix dot operator on {generate, propagate} pairs: hi covers the upper span
  function automatic logic [1:0] gp_combine(input logic [1:0] hi, input logic [1:0] lo);
    logic g;
    logic p;
    g = hi[1] | (hi[0] & lo[1]);
    p = hi[0] & lo[0];
    return {g, p};
  endfunction

endpackage

// File: rtl/wmod_dim1_front.sv
module wmod_dim1_front #(
  parameter int N = 8
) (
  input  logic [N:0]   w_in,
  output logic [N-1:0] dim_out,
  output logic         is_zero
);

  // Decrement of the low n bits: a bit flips while every lower bit is zero.
  // A value of 2^n (low bits clear) lands on the all-ones code.
  always_comb begin
    logic low_all_zero;
    low_all_zero = 1'b1;
    for (int i = 0; i < N; i++) begin
      dim_out[i]   = w_in[i] ^ low_all_zero;
      low_all_zero = low_all_zero & ~w_in[i];
    end
    is_zero = low_all_zero & ~w_in[N];
  end

  always_comb begin
    assert_dim1_code_R8: assert (N'(dim_out + 1'b1) == w_in[N-1:0])
      else $error("diminished-one code does not step back to operand");
  end

endmodule

// File: rtl/wmod_ks_core.sv
module wmod_ks_core
  import wmod_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  output logic [N-1:0] s_out,
  output logic         wrap_zero,
  output logic         eac_cin
);

  localparam int LVLS = (N > 1) ? $clog2(N) : 1;

  logic [LVLS:0][N-1:0] gg;
  logic [LVLS:0][N-1:0] pp;
  logic [N-1:0]         half_p;
  logic [N-1:0]         carry_in;

  // Kogge-Stone prefix tree over the n-bit codes
  always_comb begin
    half_p = x_in ^ y_in;
    gg[0]  = x_in & y_in;
    pp[0]  = half_p;
    for (int l = 0; l < LVLS; l++) begin
      for (int i = 0; i < N; i++) begin
        if (i >= (1 << l)) begin
          {gg[l+1][i], pp[l+1][i]} = gp_combine({gg[l][i], pp[l][i]},
                                                {gg[l][i-(1<<l)], pp[l][i-(1<<l)]});
        end else begin
          gg[l+1][i] = gg[l][i];
          pp[l+1][i] = pp[l][i];
        end
      end
    end
  end

  // Inverted end-around carry: add one only when the plain sum did not overflow
  always_comb begin
    eac_cin     = ~gg[LVLS][N-1];
    carry_in[0] = eac_cin;
    for (int i = 1; i < N; i++) begin
      carry_in[i] = gg[LVLS][i-1] | (pp[LVLS][i-1] & eac_cin);
    end
    s_out     = half_p ^ carry_in;
    wrap_zero = pp[LVLS][N-1];
  end

  function automatic logic [N-1:0] ref_dim_add(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] raw;
    raw = {1'b0, a} + {1'b0, b};
    return raw[N] ? raw[N-1:0] : N'(raw[N-1:0] + 1'b1);
  endfunction

  always_comb begin
    assert_eac_sum_R1: assert (s_out == ref_dim_add(x_in, y_in))
      else $error("end-around sum differs from diminished-one reference");
    assert_wrap_clears_R5: assert (!wrap_zero || s_out == '0)
      else $error("all-propagate sum did not wrap to zero code");
  end

endmodule

// File: rtl/wmod_dim1_back.sv
module wmod_dim1_back #(
  parameter int N = 8
) (
  input  logic [N-1:0] dim_in,
  output logic [N:0]   w_out
);

  // Increment back to weighted form; carry out of the low bits becomes bit n
  always_comb begin
    logic low_all_one;
    low_all_one = 1'b1;
    for (int i = 0; i < N; i++) begin
      w_out[i]    = dim_in[i] ^ low_all_one;
      low_all_one = low_all_one & dim_in[i];
    end
    w_out[N] = low_all_one;
  end

  always_comb begin
    assert_back_nonzero_R6: assert (w_out != '0)
      else $error("diminished-one code mapped back to zero");
    assert_back_top_R6: assert (!w_out[N] || w_out[N-1:0] == '0)
      else $error("weighted value above 2^n from incrementer");
  end

endmodule

// File: rtl/wmod_adder.sv
module wmod_adder
  import wmod_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0] op_a,
  input  logic [N:0] op_b,
  output logic [N:0] sum_o
);

  localparam int unsigned MODV = (32'd1 << N) + 32'd1;
  localparam logic [N:0]  TOPV = (N+1)'(1) << N;

  logic [N-1:0] dim_a;
  logic [N-1:0] dim_b;
  logic         zero_a;
  logic         zero_b;
  logic [N-1:0] dim_s;
  logic         wrap_zero;
  logic         eac_cin;
  logic [N:0]   core_w;
  wmod_path_e   path;

  wmod_dim1_front #(.N(N)) u_front_a (
    .w_in   (op_a),
    .dim_out(dim_a),
    .is_zero(zero_a)
  );

  wmod_dim1_front #(.N(N)) u_front_b (
    .w_in   (op_b),
    .dim_out(dim_b),
    .is_zero(zero_b)
  );

  wmod_ks_core #(.N(N)) u_core (
    .x_in     (dim_a),
    .y_in     (dim_b),
    .s_out    (dim_s),
    .wrap_zero(wrap_zero),
    .eac_cin  (eac_cin)
  );

  wmod_dim1_back #(.N(N)) u_back (
    .dim_in(dim_s),
    .w_out (core_w)
  );

  // Flag logic: zero operands bypass, a wrapped sum is the zero residue
  always_comb begin
    if (zero_a && zero_b)      path = PATH_ZERO;
    else if (zero_a)           path = PATH_B;
    else if (zero_b)           path = PATH_A;
    else if (wrap_zero)        path = PATH_ZERO;
    else                       path = PATH_CORE;
  end

  always_comb begin
    unique case (path)
      PATH_ZERO: sum_o = '0;
      PATH_A:    sum_o = op_a;
      PATH_B:    sum_o = op_b;
      default:   sum_o = core_w;
    endcase
  end

  always_comb begin
    assert_in_range_R2: assert (sum_o <= TOPV)
      else $error("result above 2^n");
    assert_zero_identity_R3: assert (!zero_a || sum_o == op_b)
      else $error("zero operand is not an identity");
    assert_mod_sum_R1: assert (32'(sum_o) == (32'(op_a) + 32'(op_b)) % MODV)
      else $error("result is not the modular sum");
    assert_wrap_only_full_R5: assert (!(wrap_zero && !zero_a && !zero_b) || eac_cin)
      else $error("zero wrap without inverted end-around carry");
  end

endmodule

// File: tb/wmod_adder_bench.sv
module wmod_adder_bench;

  localparam int NB = 8;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NB:0] a_big, b_big, s_big;
  logic [NS:0] a_sm, b_sm, s_sm;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  wmod_adder #(.N(NB)) u_wmod_adder (
    .op_a (a_big),
    .op_b (b_big),
    .sum_o(s_big)
  );

  wmod_adder #(.N(NS)) u_wmod_adder_n3 (
    .op_a (a_sm),
    .op_b (b_sm),
    .sum_o(s_sm)
  );

  function automatic int exp_sum(input int a, input int b, input int n);
    int m;
    m = (1 << n) + 1;
    return (a + b) % m;
  endfunction

  task automatic check(input string req, input int got, input int expv, input int a, input int b);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, expv);
    end
  endtask

  task automatic drive_big(input int a, input int b, input string req);
    @(posedge clk);
    a_big = (NB+1)'(a);
    b_big = (NB+1)'(b);
    @(negedge clk);
    check(req, int'(s_big), exp_sum(a, b, NB), a, b);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int top;
    int r;
    top   = 1 << NB;
    a_big = '0;
    b_big = '0;
    a_sm  = '0;
    b_sm  = '0;
    r = int'($urandom(32'd20240611));

    // Reset state: all-zero operands give zero
    @(negedge clk);
    check("R3 zero+zero", int'(s_big), 0, 0, 0);

    // R3 identity with zero operands
    drive_big(0, 77, "R3 a=0");
    drive_big(200, 0, "R3 b=0");
    drive_big(0, top, "R3 a=0 b=2^n");
    // R4 both operands at 2^n
    drive_big(top, top, "R4 top+top");
    check("R4 value", int'(s_big), top - 1, top, top);
    // R5 sum exactly modulus: end-around carry and zero override together
    drive_big(1, top, "R5 1+2^n");
    check("R5 zero", int'(s_big), 0, 1, top);
    drive_big(top, 1, "R5 2^n+1");
    drive_big(100, top + 1 - 100, "R5 complement");
    // R6 sum exactly 2^n must stay 2^n
    drive_big(top, 0, "R6 2^n+0");
    drive_big(37, top - 37, "R6 k+2^n-k");
    check("R6 top bit", int'(s_big[NB]), 1, 37, top - 37);
    // R8 operands whose codes are all ones or all zeros in the core
    drive_big(1, 1, "R8 min codes");
    drive_big(top, top - 1, "R8 max codes");

    // R7: change inputs and read back within the same cycle
    @(posedge clk);
    a_big = (NB+1)'(5);
    b_big = (NB+1)'(9);
    #1;
    check("R7 same cycle", int'(s_big), 14, 5, 9);

    // R1/R2 random legal operands
    for (int k = 0; k < 3000; k++) begin
      int a;
      int b;
      a = int'($urandom_range(0, top));
      b = int'($urandom_range(0, top));
      drive_big(a, b, "R1 random");
      checks++;
      if (int'(s_big) > top) begin
        errors++;
        $display("FAIL R2 range actual=%0d expected<=%0d", int'(s_big), top);
      end
    end

    // R9 exhaustive at n = 3
    for (int a = 0; a <= (1 << NS); a++) begin
      for (int b = 0; b <= (1 << NS); b++) begin
        @(posedge clk);
        a_sm = (NS+1)'(a);
        b_sm = (NS+1)'(b);
        @(negedge clk);
        check("R9 n=3 exhaustive", int'(s_sm), exp_sum(a, b, NS), a, b);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule